// File: doc/BRIEF.md
# Base-Offset Address Generator with Writeback

This block forms the memory address for a load or store and the updated value of its base register. A base value is combined with an offset, either added or subtracted. The offset is one of two things: a zero-extended immediate, or a register value first scaled by one of five shift operations. The shift amount comes from an immediate field.

An addressing-form input decides which value goes to memory and whether the base register is updated:
- In offset form the sum or difference is the access address and nothing is written back.
- In pre-indexed form the sum or difference is both the access address and the writeback value.
- In post-indexed form the unmodified base is the access address and the sum or difference is written back.

The access address is combinational. The writeback value and its enable are registered and appear in the cycle after an accepted request.

Top module: `agu_wb_top`

## Requirements
- R1: The updated address equals base plus the effective offset when `sub_sel` is 0, and base minus it when `sub_sel` is 1.
- R2: With `form` = 0 (offset form) or the unused code 3, `mem_addr` equals the updated address and no writeback pulse follows.
- R3: With `form` = 1 (pre-indexed), `mem_addr` equals the updated address. On the next clock `wb_en` is 1 and `wb_data` equals that same address.
- R4: With `form` = 2 (post-indexed), `mem_addr` equals `base_val`. On the next clock `wb_en` is 1 and `wb_data` equals the updated address.
- R5: When `off_is_reg` is 1, `off_reg` is scaled by `sh_kind` before use. The codes are 0 logical left, 1 logical right, 2 arithmetic right and 3 rotate right, each by `sh_amt` (0 to 31).
- R6: `sh_kind` = 4 rotates right by one through carry, giving {`carry_in`, `off_reg`[31:1]}; `sh_amt` has no effect.
- R7: A `sh_amt` of 0 leaves the register offset unchanged for shift codes 0 to 3.
- R8: When `off_is_reg` is 0, the offset is `off_imm` zero-extended to 32 bits, and `sh_kind`, `sh_amt` and `carry_in` have no effect.
- R9: Address arithmetic wraps modulo 2^32 in both directions.
- R10: `wb_en` is high for exactly one cycle per accepted pre- or post-indexed request (`req_valid` = 1). Without such a request it stays low, and `wb_data` holds its last value.
- R11: The reserved shift codes 5 to 7 pass the register offset through unchanged.
- R12: While `rst_n` is low, `wb_en` and `wb_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request accepted this cycle |
| base_val | input | 32 | Base register value |
| off_imm | input | 12 | Immediate offset |
| off_reg | input | 32 | Offset register value |
| off_is_reg | input | 1 | 1 selects the scaled register offset |
| sub_sel | input | 1 | 1 subtracts the offset |
| sh_kind | input | 3 | Shift operation code |
| sh_amt | input | 5 | Shift amount |
| carry_in | input | 1 | Carry shifted in by code 4 |
| form | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed |
| mem_addr | output | 32 | Access address |
| wb_data | output | 32 | Base writeback value |
| wb_en | output | 1 | Writeback strobe |

## Verification
On every cycle the assertions check the following:
- the pass-through at shift amount zero;
- the carry entering bit 31 under code 4;
- the choice of access address for each form;
- that the registered writeback matches the previous cycle's address (pre-indexed) or update (post-indexed);
- that no strobe appears without a request.

Only the bench's directed scenarios show the numeric results. These are every shift kind at several amounts, subtraction, wraparound at both ends of the address range, the immediate path ignoring the shift fields, the reserved codes, and `wb_data` holding across idle cycles.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } shift_e;

  typedef enum logic [1:0] {
    FM_OFFSET = 2'd0,
    FM_PRE    = 2'd1,
    FM_POST   = 2'd2
  } form_e;
endpackage

// File: rtl/agu_shifter.sv
module agu_shifter #(
  parameter int DW   = 32,
  parameter int SA_W = $clog2(DW)
) (
  input  logic [DW-1:0]   opnd,
  input  logic [2:0]      kind,
  input  logic [SA_W-1:0] amt,
  input  logic            cin,
  output logic [DW-1:0]   res
);
  import agu_pkg::*;

  function automatic logic [DW-1:0] scale(input logic [DW-1:0] x,
                                          input logic [2:0] k,
                                          input logic [SA_W-1:0] a,
                                          input logic c);
    logic [DW-1:0] r;
    case (k)
      SH_LSL:  r = x << a;
      SH_LSR:  r = x >> a;
      SH_ASR:  r = DW'($signed(x) >>> a);
      SH_ROR:  r = (a == '0) ? x : ((x >> a) | (x << (DW - int'(a))));
      SH_RRX:  r = {c, x[DW-1:1]};
      default: r = x;
    endcase
    return r;
  endfunction

  assign res = scale(opnd, kind, amt, cin);
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] off,
  input  logic          sub,
  output logic [DW-1:0] sum
);
  function automatic logic [DW-1:0] combine(input logic [DW-1:0] b,
                                            input logic [DW-1:0] o,
                                            input logic s);
    return s ? (b - o) : (b + o);
  endfunction

  assign sum = combine(base, off, sub);
endmodule

// File: rtl/agu_wb_reg.sv
module agu_wb_reg #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] next_val,
  output logic          wb_en,
  output logic [DW-1:0] wb_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en   <= 1'b0;
      wb_data <= '0;
    end else begin
      wb_en <= take;
      if (take) wb_data <= next_val;
    end
  end
endmodule

// File: rtl/agu_wb_top.sv
module agu_wb_top #(
  parameter int DW    = 32,
  parameter int IMM_W = 12,
  parameter int SA_W  = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [DW-1:0]   base_val,
  input  logic [IMM_W-1:0] off_imm,
  input  logic [DW-1:0]   off_reg,
  input  logic            off_is_reg,
  input  logic            sub_sel,
  input  logic [2:0]      sh_kind,
  input  logic [SA_W-1:0] sh_amt,
  input  logic            carry_in,
  input  logic [1:0]      form,
  output logic [DW-1:0]   mem_addr,
  output logic [DW-1:0]   wb_data,
  output logic            wb_en
);
  import agu_pkg::*;

  localparam int PAD_W = DW - IMM_W;

  logic [DW-1:0] imm_ext;
  logic [DW-1:0] shifted_off;
  logic [DW-1:0] eff_off;
  logic [DW-1:0] upd_addr;
  logic          wants_wb;
  logic          wb_take;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_ext = {{PAD_W{1'b0}}, off_imm};
    end else begin : g_trunc
      assign imm_ext = off_imm[DW-1:0];
    end
  endgenerate

  agu_shifter #(.DW(DW), .SA_W(SA_W)) u_shift (
    .opnd(off_reg), .kind(sh_kind), .amt(sh_amt), .cin(carry_in), .res(shifted_off)
  );

  assign eff_off = off_is_reg ? shifted_off : imm_ext;

  agu_addsub #(.DW(DW)) u_add (
    .base(base_val), .off(eff_off), .sub(sub_sel), .sum(upd_addr)
  );

  assign wants_wb = (form == FM_PRE) || (form == FM_POST);
  assign wb_take  = req_valid && wants_wb;
  assign mem_addr = (form == FM_POST) ? base_val : upd_addr;

  agu_wb_reg #(.DW(DW)) u_wb (
    .clk(clk), .rst_n(rst_n), .take(wb_take), .next_val(upd_addr),
    .wb_en(wb_en), .wb_data(wb_data)
  );
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int DW   = 32,
  parameter int SA_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [1:0]      form,
  input logic            off_is_reg,
  input logic [2:0]      sh_kind,
  input logic [SA_W-1:0] sh_amt,
  input logic            carry_in,
  input logic [DW-1:0]   off_reg,
  input logic [DW-1:0]   base_val,
  input logic [DW-1:0]   shifted_off,
  input logic [DW-1:0]   upd_addr,
  input logic [DW-1:0]   mem_addr,
  input logic [DW-1:0]   wb_data,
  input logic            wb_en
);
  // R7
  zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_amt == '0 && sh_kind < 3'd4) |-> shifted_off == off_reg);

  // R6
  rrx_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_kind == 3'd4) |-> (shifted_off[DW-1] == carry_in && shifted_off[DW-2:0] == off_reg[DW-1:1]));

  // R4
  post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (form == 2'd2) |-> mem_addr == base_val);

  // R2
  offset_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (form == 2'd0 || form == 2'd3) |-> mem_addr == upd_addr);

  // R3
  pre_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && form == 2'd1) |=> (wb_en && wb_data == $past(mem_addr)));

  // R4
  post_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && form == 2'd2) |=> (wb_en && wb_data == $past(upd_addr)));

  // R10
  no_req_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && (form == 2'd1 || form == 2'd2)) |=> (!wb_en && $stable(wb_data)));
endmodule

bind agu_wb_top agu_chk #(.DW(DW), .SA_W(SA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .form(form),
  .off_is_reg(off_is_reg), .sh_kind(sh_kind), .sh_amt(sh_amt), .carry_in(carry_in),
  .off_reg(off_reg), .base_val(base_val), .shifted_off(shifted_off),
  .upd_addr(upd_addr), .mem_addr(mem_addr), .wb_data(wb_data), .wb_en(wb_en)
);

// File: tb/tb_agu_wb_top.sv
`timescale 1ns/1ps
module tb_agu_wb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] base_val = '0;
  logic [11:0] off_imm = '0;
  logic [31:0] off_reg = '0;
  logic        off_is_reg = 1'b0;
  logic        sub_sel = 1'b0;
  logic [2:0]  sh_kind = '0;
  logic [4:0]  sh_amt = '0;
  logic        carry_in = 1'b0;
  logic [1:0]  form = '0;
  logic [31:0] mem_addr, wb_data;
  logic        wb_en;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  agu_wb_top dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
    .off_imm(off_imm), .off_reg(off_reg), .off_is_reg(off_is_reg), .sub_sel(sub_sel),
    .sh_kind(sh_kind), .sh_amt(sh_amt), .carry_in(carry_in), .form(form),
    .mem_addr(mem_addr), .wb_data(wb_data), .wb_en(wb_en)
  );

  function automatic logic [31:0] ref_scale(input logic [2:0] k, input logic [31:0] x,
                                            input int a, input logic c);
    logic [63:0] dbl;
    logic [63:0] sx;
    dbl = {x, x} >> a;
    sx  = {{32{x[31]}}, x} >> a;
    case (k)
      3'd0: return x << a;
      3'd1: return x >> a;
      3'd2: return sx[31:0];
      3'd3: return dbl[31:0];
      3'd4: return (x >> 1) | ({31'd0, c} << 31);
      default: return x;
    endcase
  endfunction

  function automatic logic [31:0] ref_upd(input logic [31:0] b, input logic [31:0] o,
                                          input logic s);
    logic [32:0] t;
    t = s ? ({1'b0, b} + {1'b0, ~o} + 33'd1) : ({1'b0, b} + {1'b0, o});
    return t[31:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request, check address now and writeback one edge later
  task automatic issue(input string tag, input logic v, input logic [1:0] f,
                       input logic [31:0] b, input logic isr, input logic [11:0] imm,
                       input logic [31:0] r, input logic [2:0] k, input logic [4:0] a,
                       input logic c, input logic s,
                       input logic [31:0] exp_addr, input logic exp_en,
                       input logic [31:0] exp_wbd);
    @(negedge clk);
    req_valid = v; form = f; base_val = b; off_is_reg = isr; off_imm = imm;
    off_reg = r; sh_kind = k; sh_amt = a; carry_in = c; sub_sel = s;
    #1;
    check({tag, " addr"}, mem_addr, exp_addr);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " wb_en"}, {31'd0, wb_en}, {31'd0, exp_en});
    check({tag, " wb_data"}, wb_data, exp_wbd);
  endtask

  task automatic t_reset();
    check("R12 reset wb_en", {31'd0, wb_en}, 32'd0);
    check("R12 reset wb_data", wb_data, 32'd0);
  endtask

  task automatic t_offset_form();
    logic [31:0] e;
    e = ref_upd(32'h1000, 32'h24, 1'b0);
    issue("R1 R2 offset add", 1, 2'd0, 32'h1000, 0, 12'h24, 0, 0, 0, 0, 0, e, 0, 32'd0);
    e = ref_upd(32'h1000, 32'h24, 1'b1);
    issue("R1 R2 offset sub", 1, 2'd0, 32'h1000, 0, 12'h24, 0, 0, 0, 0, 1, e, 0, 32'd0);
    issue("R2 form3 as offset", 1, 2'd3, 32'h2000, 0, 12'h10, 0, 0, 0, 0, 0, 32'h2010, 0, 32'd0);
  endtask

  task automatic t_pre();
    logic [31:0] e;
    e = ref_upd(32'h8000_0000, ref_scale(3'd0, 32'h3, 2, 0), 1'b0);
    issue("R3 pre reg lsl", 1, 2'd1, 32'h8000_0000, 1, 0, 32'h3, 3'd0, 5'd2, 0, 0, e, 1, e);
    @(negedge clk);
    check("R10 single pulse", {31'd0, wb_en}, 32'd0);
    check("R10 wb_data holds", wb_data, e);
  endtask

  task automatic t_post();
    logic [31:0] e;
    e = ref_upd(32'h4000, 32'h100, 1'b1);
    issue("R4 post sub", 1, 2'd2, 32'h4000, 0, 12'h100, 0, 0, 0, 0, 1, 32'h4000, 1, e);
    issue("R10 no valid no pulse", 0, 2'd2, 32'h5000, 0, 12'h4, 0, 0, 0, 0, 0, 32'h5000, 0, e);
  endtask

  task automatic t_shifts();
    logic [31:0] pat;
    logic [31:0] e;
    pat = 32'hC350_00A7;
    for (int k = 0; k < 4; k++) begin
      for (int a = 1; a < 32; a += 10) begin
        e = ref_upd(32'h100, ref_scale(3'(k), pat, a, 0), 1'b0);
        issue($sformatf("R5 kind%0d amt%0d", k, a), 1, 2'd0, 32'h100, 1, 0, pat,
              3'(k), 5'(a), 0, 0, e, 0, wb_data);
      end
    end
  endtask

  task automatic t_zero_amt();
    logic [31:0] pat;
    pat = 32'h9ABC_DEF1;
    for (int k = 0; k < 4; k++)
      issue($sformatf("R7 zero kind%0d", k), 1, 2'd0, 32'd0, 1, 0, pat, 3'(k), 5'd0, 0, 0,
            pat, 0, wb_data);
  endtask

  task automatic t_rrx();
    issue("R6 rrx c1 amt7", 1, 2'd0, 32'd0, 1, 0, 32'h0000_0003, 3'd4, 5'd7, 1, 0,
          32'h8000_0001, 0, wb_data);
    issue("R6 rrx c0 amt0", 1, 2'd0, 32'd0, 1, 0, 32'h8000_0002, 3'd4, 5'd0, 0, 0,
          32'h4000_0001, 0, wb_data);
  endtask

  task automatic t_imm_ignores_shift();
    issue("R8 imm ignores shift", 1, 2'd0, 32'h10, 0, 12'hFFF, 32'hFFFF_FFFF, 3'd4, 5'd9, 1, 0,
          32'h100F, 0, wb_data);
  endtask

  task automatic t_reserved();
    for (int k = 5; k < 8; k++)
      issue($sformatf("R11 reserved kind%0d", k), 1, 2'd0, 32'd1, 1, 0, 32'h0F0F_0F0F,
            3'(k), 5'd3, 1, 0, 32'h0F0F_0F10, 0, wb_data);
  endtask

  task automatic t_wrap();
    issue("R9 wrap up", 1, 2'd1, 32'hFFFF_FFF0, 0, 12'h20, 0, 0, 0, 0, 0,
          32'h0000_0010, 1, 32'h0000_0010);
    issue("R9 wrap down", 1, 2'd2, 32'h0000_0008, 0, 12'h10, 0, 0, 0, 0, 1,
          32'h0000_0008, 1, 32'hFFFF_FFF8);
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_offset_form();
    t_pre();
    t_post();
    t_shifts();
    t_zero_amt();
    t_rrx();
    t_imm_ignores_shift();
    t_reserved();
    t_wrap();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule